// File: doc/BRIEF.md
# Slow-Tick System Timer

The block is a memory-mapped system timer that runs from a 32768 Hz slow-clock enable, which arrives as a one-cycle pulse in the bus clock domain. A prescaler divides the slow ticks and advances a free-running real-time counter. An absolute-match alarm compares against that counter. A separate periodic interval timer counts slow ticks down from a programmed period. The counter advance, the alarm match and the interval expiry each latch a bit in a shared status register. Reading that register returns the pending events and clears them.

An interrupt mask is built through separate write-one-to-set and write-one-to-clear registers and can be read back. A single level-sensitive interrupt line is high while any pending event has its mask bit set. Software uses the interval timer for a fixed tick rate and the alarm for one-shot events. The alarm takes an absolute target. Writing the value the counter already holds therefore delays the match by one full counter wrap.

Register map (word index on `busAddr`): 0 interval period (RW), 1 prescaler (RW), 2 alarm target (RW), 3 counter (RO), 4 status (RO, clear on read), 5 enable set (WO), 6 enable clear (WO), 7 mask (RO). Writes to read-only indices are ignored.

Top module: `stick_timer`

## Requirements
- R1: The real-time counter is CNT_W bits (default 20). It only changes on a prescaler completion, when it advances by exactly one, and after its all-ones value it wraps to zero.
- R2: The prescaler register (index 1) gives the number of slow ticks per counter advance. It resets to 32768, a value of 1 advances the counter on every slow tick, and writing the register restarts the tick count from zero.
- R3: Status bit 3 (alarm) sets in the cycle the counter steps onto the alarm value (index 2). Writing the alarm never sets it.
- R4: If the alarm is written with the value the counter currently holds, the alarm bit sets only after 2^CNT_W further counter advances.
- R5: The interval timer sets status bit 0 on every PERIOD-th slow tick after the period (index 4... index 0) is written, then reloads and repeats. A period of 0 disables it.
- R6: Status (index 4) holds bit 0 interval, bit 1 watchdog overflow, bit 2 counter increment and bit 3 alarm. Bit 2 sets on every counter advance, and bit 1 always reads 0. A read returns the bits on the next cycle on `busRdData` and clears them.
- R7: An event that occurs in the same cycle as a status read is not returned by that read. It stays pending after the read.
- R8: Writing index 5 sets the mask bits given as ones. Writing index 6 clears the mask bits given as ones. Zero bits leave the mask unchanged, and index 7 reads the mask in bits 3:0.
- R9: `irq` is high exactly when some status bit is set and its mask bit is set.
- R10: Reset clears the counter, alarm, period, status and mask, and sets the prescaler to 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slowTick | input | 1 | One-cycle slow-clock enable |
| busAddr | input | 3 | Register word index |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered one cycle after busRdEn |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs a reduced 8-bit counter so that full wraps are cheap. It drives the prescaler at divide-by-3 and divide-by-1, which tells a correct divide ratio from an off-by-one one. The alarm is tried both with a target a few counts ahead and with a target equal to the live count. The second case separates an absolute compare on the counter step from a compare at write time, and it runs a full 256-step wrap. Interval periods of 4 and 0 check the reload and the disable, a status read coinciding with a tick checks that no event is lost, and mask writes with zero and non-zero data separate set/clear semantics from plain overwrite.

// File: rtl/stick_pkg.sv
package stick_pkg;
  localparam int unsigned ST_W    = 4;
  localparam int unsigned ST_PIT  = 0;
  localparam int unsigned ST_WDOG = 1;
  localparam int unsigned ST_INC  = 2;
  localparam int unsigned ST_ALM  = 3;
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD = 3'd0,
    REG_PRESC  = 3'd1,
    REG_ALARM  = 3'd2,
    REG_COUNT  = 3'd3,
    REG_STATUS = 3'd4,
    REG_IEN    = 3'd5,
    REG_IDIS   = 3'd6,
    REG_MASK   = 3'd7
  } regSel_t;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrPeriod;
    logic wrPresc;
    logic wrAlarm;
  } wrStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic pit;
    logic inc;
    logic alm;
  } tmrEvt_t;
endpackage

// File: rtl/stick_datapath.sv
module stick_datapath
  import stick_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned PRE_W     = 16,
  parameter int unsigned PIT_W     = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PRESC_RST = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  wrStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  alarmVal,
  output logic [PRE_W-1:0]  prescVal,
  output logic [PIT_W-1:0]  periodVal,
  output tmrEvt_t           evt
);
  localparam logic [PRE_W-1:0] PRESC_INIT = PRE_W'(PRESC_RST);

  logic [PRE_W-1:0] preCnt;
  logic [PIT_W-1:0] pitCnt;
  logic             preWrap;
  logic             advance;
  logic [CNT_W-1:0] countNext;
  logic             pitRun;
  logic             pitHit;
  logic             unusedWr;

  assign unusedWr = ^wrData;

  // prescaler completion and counter step
  always_comb begin
    preWrap   = (preCnt == PRE_W'(prescVal - 1'b1));
    advance   = slowTick && !strb.wrPresc && preWrap;
    countNext = countVal + 1'b1;
  end

  // interval timer expiry
  always_comb begin
    pitRun = slowTick && !strb.wrPeriod && (periodVal != '0);
    pitHit = pitRun && (pitCnt <= PIT_W'(1));
  end

  always_comb begin
    evt.inc = advance;
    evt.alm = advance && (countNext == alarmVal);
    evt.pit = pitHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt   <= '0;
      prescVal <= PRESC_INIT;
    end else if (strb.wrPresc) begin
      preCnt   <= '0;
      prescVal <= wrData[PRE_W-1:0];
    end else if (slowTick) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countVal <= '0;
    end else if (advance) begin
      countVal <= countNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarmVal <= '0;
    end else if (strb.wrAlarm) begin
      alarmVal <= wrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      periodVal <= '0;
      pitCnt    <= '0;
    end else if (strb.wrPeriod) begin
      periodVal <= wrData[PIT_W-1:0];
      pitCnt    <= wrData[PIT_W-1:0];
    end else if (pitRun) begin
      pitCnt <= pitHit ? periodVal : pitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/stick_ctrl.sv
module stick_ctrl
  import stick_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned PIT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  tmrEvt_t           evt,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  alarmVal,
  input  logic [PRE_W-1:0]  prescVal,
  input  logic [PIT_W-1:0]  periodVal,
  output wrStrobe_t         strb,
  output logic [ST_W-1:0]   statusQ,
  output logic [ST_W-1:0]   maskQ,
  output logic              irq
);
  regSel_t         sel;
  logic [ST_W-1:0] evtBits;
  logic            stRead;
  logic            ienWr;
  logic            idisWr;
  logic [DATA_W-1:0] rdMux;

  assign sel = regSel_t'(busAddr);

  always_comb begin
    strb.wrPeriod = busWrEn && (sel == REG_PERIOD);
    strb.wrPresc  = busWrEn && (sel == REG_PRESC);
    strb.wrAlarm  = busWrEn && (sel == REG_ALARM);
    ienWr         = busWrEn && (sel == REG_IEN);
    idisWr        = busWrEn && (sel == REG_IDIS);
    stRead        = busRdEn && (sel == REG_STATUS);
  end

  always_comb begin
    evtBits          = '0;
    evtBits[ST_PIT]  = evt.pit;
    evtBits[ST_WDOG] = 1'b0;
    evtBits[ST_INC]  = evt.inc;
    evtBits[ST_ALM]  = evt.alm;
  end

  // clear-on-read, new events always land
  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
    end else begin
      statusQ <= (stRead ? '0 : statusQ) | evtBits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ <= '0;
    end else if (ienWr) begin
      maskQ <= maskQ | busWrData[ST_W-1:0];
    end else if (idisWr) begin
      maskQ <= maskQ & ~busWrData[ST_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (sel)
      REG_PERIOD: rdMux = DATA_W'(periodVal);
      REG_PRESC:  rdMux = DATA_W'(prescVal);
      REG_ALARM:  rdMux = DATA_W'(alarmVal);
      REG_COUNT:  rdMux = DATA_W'(countVal);
      REG_STATUS: rdMux = DATA_W'(statusQ);
      REG_MASK:   rdMux = DATA_W'(maskQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busRdData <= '0;
    end else if (busRdEn) begin
      busRdData <= rdMux;
    end
  end

  assign irq = |(statusQ & maskQ);
endmodule

// File: rtl/stick_timer.sv
module stick_timer
  import stick_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned PRE_W     = 16,
  parameter int unsigned PIT_W     = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PRESC_RST = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  wrStrobe_t        strb;
  tmrEvt_t          evt;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] alarmVal;
  logic [PRE_W-1:0] prescVal;
  logic [PIT_W-1:0] periodVal;
  logic [ST_W-1:0]  statusQ;
  logic [ST_W-1:0]  maskQ;

  stick_datapath #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W),
    .DATA_W(DATA_W), .PRESC_RST(PRESC_RST)
  ) dp_i (
    .clk(clk), .rst(rst), .slowTick(slowTick), .strb(strb),
    .wrData(busWrData), .countVal(countVal), .alarmVal(alarmVal),
    .prescVal(prescVal), .periodVal(periodVal), .evt(evt)
  );

  stick_ctrl #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .evt(evt), .countVal(countVal), .alarmVal(alarmVal),
    .prescVal(prescVal), .periodVal(periodVal), .strb(strb),
    .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
  );
endmodule

// File: rtl/stick_timer_chk.sv
module stick_timer_chk #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              slowTick,
  input logic [2:0]        busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRdEn,
  input logic              irq,
  input logic [CNT_W-1:0]  countVal,
  input logic [3:0]        statusQ,
  input logic [3:0]        maskQ,
  input logic              evPit,
  input logic              evInc,
  input logic              evAlm
);
  logic unusedChk;
  assign unusedChk = ^busWrData[DATA_W-1:4];

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !slowTick |=> $stable(countVal));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (countVal != $past(countVal)) |-> (countVal == CNT_W'($past(countVal) + 1'b1)));

  assert_wdog_zero_R6: assert property (@(posedge clk) disable iff (rst)
    statusQ[1] == 1'b0);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr == 3'd4 && !(evPit || evInc || evAlm)) |=> (statusQ == 4'b0));

  assert_event_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr == 3'd4 && evInc) |=> statusQ[2]);

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == 3'd5) |=> ((maskQ & $past(busWrData[3:0])) == $past(busWrData[3:0])));

  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == 3'd6) |=> ((maskQ & $past(busWrData[3:0])) == 4'b0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (maskQ == 4'b0) |-> !irq);
endmodule

bind stick_timer stick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .slowTick(slowTick), .busAddr(busAddr),
  .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn), .irq(irq),
  .countVal(countVal), .statusQ(statusQ), .maskQ(maskQ),
  .evPit(evt.pit), .evInc(evt.inc), .evAlm(evt.alm)
);

// File: tb/stick_timer_tb.sv
module stick_timer_tb_top;
  localparam int CW   = 8;
  localparam int WRAP = 1 << CW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slowTick = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int mPresc = 32768;
  int mPre = 0;
  int mCount = 0;

  always #5 clk = ~clk;

  stick_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .slowTick(slowTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelTick();
    mPre++;
    if (mPre >= mPresc) begin
      mPre = 0;
      mCount = (mCount + 1) % WRAP;
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a == 3'd1) begin
      mPresc = (d[15:0] == 0) ? 65536 : int'(d[15:0]);
      mPre = 0;
    end
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
      modelTick();
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=done", 100000);
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset values
    chk("R10 irq", {31'b0, irq}, 32'd0);
    busRead(3'd1, v); chk("R10 prescaler", v, 32'd32768);
    busRead(3'd3, v); chk("R10 counter", v, 32'd0);
    busRead(3'd2, v); chk("R10 alarm", v, 32'd0);
    busRead(3'd4, v); chk("R10 status", v, 32'd0);
    busRead(3'd7, v); chk("R10 mask", v, 32'd0);

    // R2: default divide holds counter, then divide-by-3
    ticks(3);
    busRead(3'd3, v); chk("R2 default divide", v, 32'(mCount));
    busWrite(3'd1, 32'd3);
    ticks(8);
    busRead(3'd3, v); chk("R2 divide by 3 after 8 ticks", v, 32'd2);
    ticks(1);
    busRead(3'd3, v); chk("R1 step on 9th tick", v, 32'd3);

    // R2/R6: divide by one, increment bit, clear on read
    busWrite(3'd1, 32'd1);
    busRead(3'd4, v);
    ticks(1);
    busRead(3'd3, v); chk("R2 divide by 1", v, 32'(mCount));
    busRead(3'd4, v); chk("R6 increment bit", v, 32'h4);
    busRead(3'd4, v); chk("R6 cleared by read", v, 32'h0);

    // R3: alarm a few counts ahead
    busWrite(3'd2, 32'(mCount + 6));
    busRead(3'd4, v); chk("R3 no alarm on write", v, 32'h0);
    ticks(5);
    busRead(3'd4, v); chk("R3 not yet at alarm", v, 32'h4);
    ticks(1);
    busRead(3'd4, v); chk("R3 alarm on step", v, 32'hC);

    // R4: alarm equal to current count waits one full wrap
    busRead(3'd3, c0);
    busWrite(3'd2, c0);
    busRead(3'd4, v);
    ticks(WRAP - 1);
    busRead(3'd4, v); chk("R4 no alarm before wrap", v, 32'h4);
    busRead(3'd3, v); chk("R1 wrap arithmetic", v, 32'((c0 + WRAP - 1) % WRAP));
    ticks(1);
    busRead(3'd4, v); chk("R4 alarm after full wrap", v, 32'hC);

    // R5: interval timer period 4, then disabled
    busWrite(3'd0, 32'd4);
    busRead(3'd4, v);
    ticks(3);
    busRead(3'd4, v); chk("R5 before period", v, 32'h4);
    ticks(1);
    busRead(3'd4, v); chk("R5 period elapsed", v, 32'h5);
    ticks(3);
    busRead(3'd4, v); chk("R5 reload not early", v, 32'h4);
    ticks(1);
    busRead(3'd4, v); chk("R5 second period", v, 32'h5);
    busWrite(3'd0, 32'd0);
    ticks(10);
    busRead(3'd4, v); chk("R5 period zero disables", v, 32'h4);

    // R8: set/clear mask
    busWrite(3'd5, 32'h9);
    busRead(3'd7, v); chk("R8 enable set", v, 32'h9);
    busWrite(3'd5, 32'h0);
    busRead(3'd7, v); chk("R8 zero enable no effect", v, 32'h9);
    busWrite(3'd6, 32'h1);
    busRead(3'd7, v); chk("R8 disable clear", v, 32'h8);
    busWrite(3'd6, 32'h0);
    busRead(3'd7, v); chk("R8 zero disable no effect", v, 32'h8);

    // R9: interrupt level
    busWrite(3'd5, 32'h4);
    busRead(3'd4, v);
    chk("R9 idle irq low", {31'b0, irq}, 32'd0);
    ticks(1);
    chk("R9 irq on enabled event", {31'b0, irq}, 32'd1);
    busRead(3'd4, v);
    chk("R9 irq drops after read", {31'b0, irq}, 32'd0);
    busWrite(3'd6, 32'h4);
    ticks(1);
    chk("R9 masked event no irq", {31'b0, irq}, 32'd0);
    busWrite(3'd5, 32'h4);
    chk("R9 enable on pending event", {31'b0, irq}, 32'd1);
    busRead(3'd4, v); chk("R6 watchdog bit zero", v & 32'h2, 32'h0);

    // R7: event in the same cycle as a status read
    @(negedge clk);
    busAddr = 3'd4; busRdEn = 1'b1; slowTick = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; slowTick = 1'b0;
    modelTick();
    chk("R7 read excludes same-cycle event", busRdData, 32'h0);
    busRead(3'd4, v); chk("R7 event kept pending", v, 32'h4);
    busRead(3'd3, v); chk("R1 final count", v, 32'(mCount));

    finishRun();
  end
endmodule